// File: doc/BRIEF.md
# Periodic Preamble Synchronizer

This block sits behind a bit slicer or clock recovery loop and watches the incoming serial bit stream, one bit per strobe, for a synchronization preamble. The preamble is a period of three ones followed by three zeros, repeated many times. A single period can be matched at any of its repetitions. A stream that matches at one repetition therefore also matches at every shift by a whole number of periods. To resolve that ambiguity the block counts consecutive periods that line up exactly six bits apart. It declares lock only after a configurable minimum number of them.

On lock it emits a one-cycle `sync_found` pulse that marks the boundary after the last zero of a qualifying period. That pulse can load the phase of the clock recovery loop. It also restarts a data block counter that indexes the following 30-bit blocks. The counter reports the first bit of each block and pulses at the end of each block. Blocks run back to back until a new preamble re-aligns them. The detector stays armed at all times, so a preamble repeated inside a transmission re-aligns the block framing.

Top module: `preamble_sync_detector`

## Requirements
- R1: While reset is asserted and until the first accepted bit, `sync_found`, `block_start` and `block_done` are 0 and `bit_idx` is 0.
- R2: In the cycle after the accepted bit (`bit_valid`=1) that completes MIN_PERIODS (default 4) consecutive copies of the period, `sync_found` is 1 for exactly one cycle. The bits of each copy arrive in the order 1,1,1,0,0,0.
- R3: A preamble cut short, with fewer than MIN_PERIODS consecutive copies, gives no `sync_found`. So does a preamble in which any bit breaks the period. A count broken this way restarts from zero.
- R4: Each further complete copy after the MIN_PERIODS-th gives another one-cycle `sync_found` and restarts the block at index 0.
- R5: A cycle with `bit_valid`=0 is ignored. `bit_in` has no effect, and the period count and block index are held.
- R6: After `sync_found`, `bit_idx` gives the index (0 to 29) of the next data bit to arrive. `block_start` is 1, combinationally, while the first data bit of a block (index 0) is presented with `bit_valid`=1.
- R7: In the cycle after the 30th data bit of a block is accepted, `block_done` is 1 for one cycle and `bit_idx` returns to 0. The next block follows with no gap.
- R8: Extra ones or zeros before the preamble do not prevent lock. Alignment is taken from the last six accepted bits, not from the first one seen.
- R9: After lock and data, a new preamble of MIN_PERIODS copies locks again and re-aligns the block index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_valid | input | 1 | Strobe: `bit_in` carries a new bit this cycle |
| bit_in | input | 1 | Received bit |
| sync_found | output | 1 | One-cycle pulse after the preamble qualifies |
| block_start | output | 1 | The presented bit is the first bit of a data block |
| block_done | output | 1 | One-cycle pulse after the last bit of a data block |
| bit_idx | output | 5 | Index of the next data bit within the block |

## Verification
On every cycle the assertions check a set of timing rules. `sync_found` never fires on two consecutive cycles, and it always follows an accepted zero. The period count never passes its saturation value. The block index stays below the block length and holds on idle strobes. `block_done` always leaves the index at zero. Only the bench scenarios can show the following: lock lands on the exact bit, short or broken preambles are rejected, leading noise does not prevent lock, and re-locking re-aligns the block framing. The bench does this by comparing against a model that inspects the last MIN_PERIODS×6 accepted bits.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned RUN_LEN = 3;
  localparam int unsigned PER_LEN = 2 * RUN_LEN;
  localparam logic [PER_LEN-1:0] PERIOD_PAT = {{RUN_LEN{1'b1}}, {RUN_LEN{1'b0}}};
endpackage

// File: rtl/psd_period_track.sv
module psd_period_track
  import psd_pkg::*;
#(
  parameter int unsigned MIN_PERIODS = 4,
  localparam int unsigned CW = $clog2(MIN_PERIODS + 1),
  localparam int unsigned GW = $clog2(PER_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  output logic hit,
  output logic sync_found
);
  logic [PER_LEN-1:0] win_q, win_d;
  logic [GW-1:0]      gap_q, gap_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic               match;

  localparam logic [GW-1:0] GAP_LAST = GW'(PER_LEN - 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(MIN_PERIODS);

  always_comb begin
    win_d = win_q;
    gap_d = gap_q;
    cnt_d = cnt_q;
    match = 1'b0;
    hit   = 1'b0;
    if (bit_valid) begin
      win_d = {win_q[PER_LEN-2:0], bit_in};
      match = (win_d == PERIOD_PAT);
      if (match) begin
        gap_d = '0;
        if (cnt_q != '0 && gap_q == GAP_LAST)
          cnt_d = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
        else
          cnt_d = CW'(1);
        hit = (cnt_d >= CNT_MAX);
      end else begin
        if (gap_q == GAP_LAST) cnt_d = '0;
        else                   gap_d = gap_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q      <= '0;
      gap_q      <= '0;
      cnt_q      <= '0;
      sync_found <= 1'b0;
    end else begin
      if (bit_valid) begin
        win_q <= win_d;
        gap_q <= gap_d;
        cnt_q <= cnt_d;
      end
      sync_found <= hit;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX) else $error("period count overflow"); // R3
  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found |=> !sync_found) else $error("sync pulse too long"); // R2
  AST_SYNC_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found |-> $past(bit_valid && !bit_in)) else $error("sync without final zero"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> ($stable(cnt_q) && $stable(win_q) && !sync_found)) else $error("idle strobe changed state"); // R5
endmodule

// File: rtl/psd_block_count.sv
module psd_block_count #(
  parameter int unsigned BLOCK_BITS = 30,
  localparam int unsigned IW = $clog2(BLOCK_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_valid,
  input  logic          load,
  output logic          block_start,
  output logic          block_done,
  output logic [IW-1:0] bit_idx
);
  localparam logic [IW-1:0] IDX_LAST = IW'(BLOCK_BITS - 1);

  logic          act_q, act_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          done_d;

  always_comb begin
    act_d  = act_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (load) begin
      act_d = 1'b1;
      idx_d = '0;
    end else if (bit_valid && act_q) begin
      if (idx_q == IDX_LAST) begin
        idx_d  = '0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      idx_q      <= '0;
      block_done <= 1'b0;
    end else begin
      if (bit_valid) begin
        act_q <= act_d;
        idx_q <= idx_d;
      end
      block_done <= done_d;
    end
  end

  assign block_start = act_q && bit_valid && (idx_q == '0) && !load;
  assign bit_idx     = idx_q;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_LAST) else $error("index out of range"); // R6
  AST_DONE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |-> (idx_q == '0)) else $error("done without wrap"); // R7
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> ($stable(idx_q) && !block_done)) else $error("index moved on idle"); // R5
endmodule

// File: rtl/preamble_sync_detector.sv
module preamble_sync_detector #(
  parameter int unsigned MIN_PERIODS = 4,
  parameter int unsigned BLOCK_BITS  = 30,
  localparam int unsigned IW = $clog2(BLOCK_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_valid,
  input  logic          bit_in,
  output logic          sync_found,
  output logic          block_start,
  output logic          block_done,
  output logic [IW-1:0] bit_idx
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;
  logic       hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  psd_period_track #(.MIN_PERIODS(MIN_PERIODS)) u_track (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .hit       (hit),
    .sync_found(sync_found)
  );

  psd_block_count #(.BLOCK_BITS(BLOCK_BITS)) u_blk (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .bit_valid  (bit_valid),
    .load       (hit),
    .block_start(block_start),
    .block_done (block_done),
    .bit_idx    (bit_idx)
  );

  AST_DONE_NOT_SYNC: assert property (@(posedge clk) disable iff (!rst_n_s)
    sync_found |-> !block_done) else $error("sync and done together"); // R4
endmodule

// File: tb/preamble_sync_detector_bench.sv
`timescale 1ns/1ps
module preamble_sync_detector_bench;
  localparam int unsigned MINP = 4;
  localparam int unsigned BLK  = 30;
  localparam int unsigned WIN  = 6 * MINP;

  logic clk = 1'b0;
  logic rst_n;
  logic bit_valid, bit_in;
  logic sync_found, block_start, block_done;
  logic [4:0] bit_idx;

  always #2.5 clk = ~clk;

  preamble_sync_detector #(.MIN_PERIODS(MINP), .BLOCK_BITS(BLK)) u_preamble_sync_detector (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .sync_found(sync_found), .block_start(block_start),
    .block_done(block_done), .bit_idx(bit_idx)
  );

  int    errors = 0;
  int    checks = 0;
  bit    finished = 0;
  string cur_tag = "R1";

  logic [63:0] hist;
  logic        e_sync, e_done, e_act;
  int          e_idx;

  function automatic logic [63:0] rep_pattern();
    logic [63:0] p = '0;
    for (int k = 0; k < int'(MINP); k++) p = {p[57:0], 6'b111000};
    return p;
  endfunction

  function automatic bit window_hit(logic [63:0] h);
    logic [63:0] m = (64'd1 << WIN) - 64'd1;
    return (h & m) == rep_pattern();
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", cur_tag, what, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic b);
    @(negedge clk);
    chk(32'(sync_found), 32'(e_sync), "sync_found");
    chk(32'(block_done), 32'(e_done), "block_done");
    chk(32'(bit_idx), 32'(e_idx), "bit_idx");
    bit_valid = v;
    bit_in    = b;
    #1;
    chk(32'(block_start), 32'(e_act && e_idx == 0 && v && !(window_hit({hist[62:0], b}))), "block_start");
    @(posedge clk);
    e_sync = 1'b0;
    e_done = 1'b0;
    if (v) begin
      hist = {hist[62:0], b};
      if (window_hit(hist)) begin
        e_sync = 1'b1; e_act = 1'b1; e_idx = 0;
      end else if (e_act) begin
        if (e_idx == int'(BLK) - 1) begin e_idx = 0; e_done = 1'b1; end
        else e_idx++;
      end
    end
  endtask

  task automatic send_periods(input int n, input bit gaps);
    for (int p = 0; p < n; p++)
      for (int i = 0; i < 6; i++) begin
        if (gaps && ($urandom % 3 == 0)) step(1'b0, 1'($urandom));
        step(1'b1, (i < 3) ? 1'b1 : 1'b0);
      end
  endtask

  task automatic send_data(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'($urandom));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    hist = '0; e_sync = 0; e_done = 0; e_act = 0; e_idx = 0;
    bit_valid = 0; bit_in = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_tag = "R1";
    chk(32'(sync_found), 0, "sync_found in reset");
    chk(32'(block_done), 0, "block_done in reset");
    chk(32'(block_start), 0, "block_start in reset");
    chk(32'(bit_idx), 0, "bit_idx in reset");
    rst_n = 1;
    repeat (4) @(posedge clk);
    cur_tag = "R1"; step(1'b0, 1'b1); step(1'b0, 1'b0);

    cur_tag = "R2"; send_periods(MINP, 0);
    cur_tag = "R6"; send_data(12);
    cur_tag = "R7"; send_data(18 + 35);

    cur_tag = "R3"; send_periods(MINP - 1, 0);
    step(1'b1, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b0); step(1'b1, 1'b1);
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    send_periods(MINP - 1, 0);
    step(1'b1, 1'b1); step(1'b1, 1'b1);

    cur_tag = "R5"; send_periods(MINP, 1);
    for (int i = 0; i < 6; i++) step(1'b0, 1'($urandom));
    send_data(5);

    cur_tag = "R4"; send_periods(MINP + 2, 0);
    send_data(BLK);

    cur_tag = "R8"; step(1'b1, 1); step(1'b1, 1); step(1'b1, 1); step(1'b1, 1);
    step(1'b1, 0); step(1'b1, 0); step(1'b1, 0); step(1'b1, 0); step(1'b1, 1);
    send_periods(MINP, 0);
    send_data(40);

    cur_tag = "R9"; send_data(17); send_periods(MINP, 0); send_data(BLK + 3);

    cur_tag = "RND";
    for (int r = 0; r < 25; r++) begin
      for (int i = 0; i < int'($urandom % 8); i++) step(1'($urandom % 4 != 0), 1'($urandom));
      send_periods(int'($urandom % (MINP + 3)), 1'($urandom));
      for (int i = 0; i < int'($urandom % 70); i++) step(1'($urandom % 5 != 0), 1'($urandom));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule